// File: doc/BRIEF.md
# Self-clocked serial result sequencer

This block is the digital read-out side of a converter that produces its own serial clock. It moves through three states: converting, sleeping with a result held, and shifting that result out. A host controls it with an active-low select line. Pulling select low during a conversion shows a busy status on the data line. Pulling it low while the block sleeps shows a ready status. After a fixed hold-off the block starts clocking out a 24-bit frame on its own. The frame is a status bit followed by the result word, most significant bit first.

A cycle counter stands in for the analog converter. When the count runs out, the word on `conv_word` is copied into a static shift register. At the end of a frame a new conversion starts at once. Raising select part way through a frame also starts a new conversion, which lets a host read only the leading bits. Raising select during the hold-off returns the block to sleep with the stored word intact. All state changes are synchronous to `clk`. Select passes through a two-flop synchroniser first.

Top module: `serout_seq`

## Requirements
- R1: `sdo_oe` equals the inverse of `cs_n` as sampled two clock edges earlier, so the data line is released while select is high. While select is high the block holds `sck` high.
- R2: When select falls during a conversion, `sck` is low and `sdo` is 1 (busy) three clocks after the fall.
- R3: When select is low and the block holds a finished result but has not started clocking, `sdo` is 0 (ready) and `sck` is low.
- R4: The first rising `sck` edge comes HOLD_CYCLES+3 clocks after select falls on a sleeping block. If a conversion ends while select is already low, `sck` falls and the first rising edge comes HOLD_CYCLES clocks after that fall.
- R5: A frame has FRAME_W rising `sck` edges spaced DIV clocks apart. Each rising edge is followed by DIV/2 high clocks. At rising edge 1 `sdo` is 0 (status). At rising edges 2 to FRAME_W `sdo` carries `conv_word` from bit FRAME_W-2 down to bit 0.
- R6: Inside a frame, `sdo` changes only when `sck` falls and stays steady while `sck` is high.
- R7: After the last rising edge of a frame, `sck` stays high and `sdo` shows 1. A new conversion of CONV_CYCLES clocks begins, so with select held low `sck` next falls DIV/2+CONV_CYCLES clocks after that last rising edge.
- R8: If select rises before the first rising `sck` edge, no clock edge is produced and the block sleeps again. The next read-out returns the same word.
- R9: If select rises during a frame, the frame stops and a new conversion starts, so a select fall shortly afterwards reads busy status (`sdo` = 1).
- R10: The word shifted out is the value on `conv_word` in the last clock of the conversion. Earlier values are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; the block starts a conversion on release |
| cs_n | input | 1 | Host select, active low, asynchronous to `clk` |
| conv_word | input | FRAME_W-1 | Result presented by the converter model |
| sck | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Output enable for the data pad, 1 = drive |

## Verification
The checker assumes `cs_n` is held steady around every rising `clk` edge and changes at most once per clock. That lets the two-flop delay on the data enable be compared exactly. It also assumes select stays low long enough for a hold-off to finish whenever a frame is expected. The stimulus changes `cs_n` and `conv_word` only on falling clock edges. It holds each select level for several clocks, and it waits well past the conversion length before any test that expects the sleep state.

// File: rtl/serout_pkg.sv
// Shared types for the self-clocked serial result sequencer.
package serout_pkg;
    // Sequencer states; WAIT is the hold-off between status test and clocking.
    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAIT  = 2'd2,
        ST_OUT   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/serout_cs_sync.sv
// Two-flop synchroniser for the host select line.
// Assumes: cs_n may change at any time; output is valid two edges later.
// Reset value is 1 (deselected).
module serout_cs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_s
);
    logic meta;

    // Shift the raw select through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b1;
            cs_s <= 1'b1;
        end else begin
            meta <= cs_n;
            cs_s <= meta;
        end
    end
endmodule

// File: rtl/serout_conv_timer.sv
// Conversion-time model: counts CONV_CYCLES clocks while run is high.
// done is high in the last clock of the count. The counter clears when run drops.
// Assumes: the caller leaves the converting state on done.
module serout_conv_timer #(
    parameter int CONV_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    // Advance the conversion count; idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/serout_shifter.sv
// Static result register: loads {status 0, word}, shifts left and fills with 1.
// Holds its value when neither load nor shift is asserted.
// Assumes: load and shift are never high together.
module serout_shifter #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-2:0] word,
    output logic               msb
);
    logic [FRAME_W-1:0] sreg;

    assign msb = sreg[FRAME_W-1];

    // Capture a new result or advance by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '1;
        end else if (load) begin
            sreg <= {1'b0, word};
        end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/serout_ctrl.sv
// Sequencer control: state machine, hold-off count, SCK divider and bit count.
// Assumes: cs_s is already synchronised; DIV is even and at least 2;
// HOLD_CYCLES is at least 1.
module serout_ctrl
    import serout_pkg::*;
#(
    parameter int FRAME_W     = 24,
    parameter int DIV         = 8,
    parameter int HOLD_CYCLES = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       conv_done,
    output seq_state_e state,
    output logic       sck,
    output logic       load,
    output logic       shift
);
    localparam int HALF = DIV / 2;
    localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW   = $clog2(FRAME_W);
    localparam int HW   = $clog2(HOLD_CYCLES + 1);
    localparam logic [PW-1:0] PH_HALF  = PW'(HALF);
    localparam logic [PW-1:0] PH_FALL  = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_WRAP  = PW'(DIV - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYCLES - 1);

    logic [PW-1:0] ph;
    logic [PW-1:0] ph_nxt;
    logic [BW-1:0] bit_cnt;
    logic [HW-1:0] hold_cnt;
    logic          cs_d;
    logic          cs_fall;
    logic          frame_end;

    assign cs_fall   = cs_d && !cs_s;
    assign ph_nxt    = (ph == PH_WRAP) ? '0 : ph + 1'b1;
    assign frame_end = (ph == PH_FALL) && (bit_cnt == LAST_BIT);
    assign load      = (state == ST_CONV) && conv_done;
    assign shift     = (state == ST_OUT) && !cs_s && (ph == PH_FALL) && !frame_end;

    // State transitions, SCK generation and the counters that time them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CONV;
            sck      <= 1'b1;
            ph       <= '0;
            bit_cnt  <= '0;
            hold_cnt <= '0;
            cs_d     <= 1'b1;
        end else begin
            cs_d <= cs_s;
            unique case (state)
                ST_CONV: begin
                    if (cs_s)         sck <= 1'b1;
                    else if (cs_fall) sck <= 1'b0;
                    if (conv_done) begin
                        hold_cnt <= '0;
                        if (cs_s) begin
                            state <= ST_SLEEP;
                        end else begin
                            state <= ST_WAIT;
                            sck   <= 1'b0;
                        end
                    end
                end
                ST_SLEEP: begin
                    sck <= 1'b1;
                    if (!cs_s) begin
                        state    <= ST_WAIT;
                        hold_cnt <= '0;
                        sck      <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (cs_s) begin
                        state <= ST_SLEEP;
                        sck   <= 1'b1;
                    end else if (hold_cnt == HOLD_END) begin
                        state   <= ST_OUT;
                        ph      <= '0;
                        bit_cnt <= '0;
                        sck     <= 1'b1;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                ST_OUT: begin
                    if (cs_s) begin
                        state <= ST_CONV;
                        sck   <= 1'b1;
                    end else if (frame_end) begin
                        state <= ST_CONV;
                    end else begin
                        ph  <= ph_nxt;
                        sck <= (ph_nxt < PH_HALF);
                        if (ph == PH_WRAP) bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_CONV;
            endcase
        end
    end
endmodule

// File: rtl/serout_seq.sv
// Self-clocked serial result sequencer (top).
// Converts, sleeps with the result held, and shifts out a status bit plus word
// on a generated SCK. A select rise mid-frame aborts and restarts conversion.
// Assumes: cs_n is asynchronous; the sdo/sdo_oe pair drives a tri-state pad.
module serout_seq
    import serout_pkg::*;
#(
    parameter int FRAME_W     = 24,
    parameter int DIV         = 8,
    parameter int HOLD_CYCLES = 15,
    parameter int CONV_CYCLES = 4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic [FRAME_W-2:0] conv_word,
    output logic               sck,
    output logic               sdo,
    output logic               sdo_oe
);
    seq_state_e state;
    logic       cs_s;
    logic       conv_done;
    logic       load;
    logic       shift;
    logic       frame_msb;

    serout_cs_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .cs_s  (cs_s)
    );

    serout_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_CONV),
        .done  (conv_done)
    );

    serout_ctrl #(
        .FRAME_W     (FRAME_W),
        .DIV         (DIV),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .conv_done (conv_done),
        .state     (state),
        .sck       (sck),
        .load      (load),
        .shift     (shift)
    );

    serout_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .word  (conv_word),
        .msb   (frame_msb)
    );

    // Busy status while converting, otherwise the head of the result register.
    assign sdo    = (state == ST_CONV) ? 1'b1 : frame_msb;
    assign sdo_oe = !cs_s;
endmodule

// File: rtl/serout_seq_chk.sv
// Protocol checker for serout_seq, attached with bind.
// Assumes: cs_n is stable around each rising clk edge.
module serout_seq_chk
    import serout_pkg::*;
#(
    parameter int HOLD_CYCLES = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       cs_s,
    input seq_state_e state,
    input logic       sck,
    input logic       sdo,
    input logic       sdo_oe
);
    logic [1:0]  cyc;
    logic [15:0] wait_len;

    // Count edges since reset (saturating) and the length of each hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= '0;
            wait_len <= '0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 1'b1;
            wait_len <= (state == ST_WAIT) ? wait_len + 1'b1 : 16'd0;
        end
    end

    a_r1_oe_tracks_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (sdo_oe == !$past(cs_n, 2)));

    a_r3_ready_status: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP || state == ST_WAIT) && sdo_oe) |-> !sdo);

    a_r4_holdoff_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && $past(state) == ST_WAIT) |-> (wait_len == 16'(HOLD_CYCLES)));

    a_r6_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && $past(state) == ST_OUT && sck && $past(sck)) |-> $stable(sdo));

    a_r7_frame_exit_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_OUT && state == ST_CONV) |-> (sck && sdo));

    a_r8_release_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && cs_s) |=> (state == ST_SLEEP));

    a_r9_abort_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && cs_s) |=> (state == ST_CONV));
endmodule

bind serout_seq serout_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .cs_s   (cs_s),
    .state  (state),
    .sck    (sck),
    .sdo    (sdo),
    .sdo_oe (sdo_oe)
);

// File: tb/serout_seq_test.sv
// Directed bench for serout_seq; samples on falling edges, drives on falling edges.
module serout_seq_test;
    localparam int FW   = 24;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int HOLD = 6;
    localparam int CONV = 80;
    localparam logic [FW-2:0] W0 = 23'h15A5A5;
    localparam logic [FW-2:0] W1 = 23'h6C3E91;
    localparam logic [FW-2:0] W2 = 23'h0F00F1;
    localparam logic [FW-2:0] W3 = 23'h2BCD17;
    localparam logic [FW-2:0] W4 = 23'h7E0183;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic [FW-2:0] conv_word = W0;
    logic          sck, sdo, sdo_oe;
    logic          p_sck = 1'b1, c_sck = 1'b1;
    int            vectors = 0, miscompares = 0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    serout_seq #(.FRAME_W(FW), .DIV(DIV), .HOLD_CYCLES(HOLD), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conv_word(conv_word),
        .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        p_sck = c_sck;
        c_sck = sck;
    endtask

    // Number of samples until the next sampled 0->1 on sck.
    task automatic wait_rise(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!(!p_sck && c_sck) && n < 5000);
        if (n >= 5000) check("R5 sck rise timeout", 0, 1);
    endtask

    // Capture nbits rising edges; first gap checked against first_exp.
    // After each non-final edge one extra high sample is used for the R6 check,
    // so the following gap is DIV-HALF+1 samples.
    task automatic read_bits(input int nbits, input int first_exp, input string tag,
                             output logic [FW-1:0] w);
        int n;
        logic b;
        w = '0;
        for (int i = 0; i < nbits; i++) begin
            wait_rise(n);
            if (i == 0) check(tag, n, first_exp);
            else        check("R5 sck period", n, DIV - HALF + 1);
            b = sdo;
            w = {w[FW-2:0], b};
            if (i < nbits - 1) begin
                for (int j = 1; j < HALF; j++) begin
                    tick();
                    check("R6 sdo steady while sck high", {31'd0, sdo}, {31'd0, b});
                end
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check("R1 released during reset", {31'd0, sdo_oe}, 32'd0);
        check("R1 sck idle high", {31'd0, sck}, 32'd1);
        rst_n = 1'b1;
        tick();
        check("R1 released after reset", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic t_busy_status();
        cs_n = 1'b0;
        tick();
        check("R1 enable waits for sync", {31'd0, sdo_oe}, 32'd0);
        tick();
        check("R1 enable after two edges", {31'd0, sdo_oe}, 32'd1);
        tick();
        check("R2 sck low on status test", {31'd0, sck}, 32'd0);
        check("R2 busy status", {31'd0, sdo}, 32'd1);
        cs_n = 1'b1;
        conv_word = W1;  // R10: changed before conversion ends
        repeat (3) tick();
        check("R1 released after select rise", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic t_sleep_readout();
        logic [FW-1:0] w;
        int c;
        repeat (CONV + 20) tick();
        cs_n = 1'b0;
        repeat (3) tick();
        check("R3 ready status", {31'd0, sdo}, 32'd0);
        check("R3 sck low", {31'd0, sck}, 32'd0);
        read_bits(FW, HOLD, "R4 hold-off from select fall", w);
        check("R5 R10 frame contents", {8'd0, w}, {8'd0, 1'b0, W1});
        conv_word = W2;
        c = 0;
        do begin
            tick();
            c++;
            if (c == HALF) begin
                check("R7 sck held high after frame", {31'd0, sck}, 32'd1);
                check("R7 busy after frame", {31'd0, sdo}, 32'd1);
            end
        end while (sck && c < 5000);
        check("R7 conversion restart length", c, HALF + CONV);
        read_bits(FW, HOLD, "R4 hold-off from conversion end", w);
        check("R10 second frame contents", {8'd0, w}, {8'd0, 1'b0, W2});
    endtask

    task automatic t_abort();
        logic [FW-1:0] w;
        conv_word = W3;
        read_bits(6, HALF + CONV + HOLD, "R7 restart then next frame", w);
        check("R9 leading bits before abort", {26'd0, w[5:0]}, {26'd0, 1'b0, W3[22:18]});
        cs_n = 1'b1;
        repeat (2) tick();
        check("R9 R1 released on abort", {31'd0, sdo_oe}, 32'd0);
        repeat (3) tick();
        cs_n = 1'b0;
        conv_word = W4;
        repeat (3) tick();
        check("R9 busy after abort", {31'd0, sdo}, 32'd1);
        check("R9 enabled for status", {31'd0, sdo_oe}, 32'd1);
        cs_n = 1'b1;
    endtask

    task automatic t_sleep_return();
        logic [FW-1:0] w;
        repeat (CONV + 20) tick();
        cs_n = 1'b0;
        repeat (3) tick();
        check("R3 ready before release", {31'd0, sdo}, 32'd0);
        tick();
        cs_n = 1'b1;
        repeat (2) tick();
        check("R8 no sck edge before release acts", {31'd0, sck}, 32'd0);
        repeat (10) tick();
        check("R8 idle high after release", {31'd0, sck}, 32'd1);
        conv_word = W0;
        cs_n = 1'b0;
        read_bits(FW, HOLD + 3, "R4 hold-off from select fall", w);
        check("R8 result retained", {8'd0, w}, {8'd0, 1'b0, W4});
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    initial begin
        t_reset();
        t_busy_status();
        t_sleep_readout();
        t_abort();
        t_sleep_return();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule